// File: doc/BRIEF.md
# VME Transfer Sequencer

This block runs one complete VME bus transfer through a VME controller that offers a 64-location, byte-wide local register space. It never drives the backplane. It takes one transfer request and breaks it into a fixed series of controller I/O cycles:

1. Four address-byte writes.
2. One address-control write.
3. Data writes, for a write transfer.
4. A strobe-setting write.
5. Status polls.
6. Data reads, for a read transfer.
7. A strobe-clearing write.

When the series is finished it reports read data, a bus-error flag and a timeout flag, together with a one-clock done pulse.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The requester may hold `req_valid` high for as long as it likes: nothing is lost and nothing is taken twice, because `req_ready` drops on the very next cycle and stays low until after done. The response side is plain status:

- `done` pulses for one clock.
- `rsp_rdata`, `rsp_berr` and `rsp_tmo` hold their values until the next done pulse.

Old software sets the upper base-address bytes by writing to three special offsets. The sequencer catches those writes in three shadow bytes and does not put them on the bus. A later request whose upper 24 address bits are zero uses the shadow bytes as its upper address.

Top module: `vme_seq_master`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and all response outputs are 0. `req_ready` is 1 only while idle. A request is accepted when `req_valid` and `req_ready` are both 1, and `req_ready` is 0 on the next cycle.
- R2: A bus transfer first writes the address bytes to locations 42, 43, 44 and 45, in that order. Location 42 gets the most significant byte. Location 45 gets address bits 7..1 with bit 0 written as 0.
- R3: Location 46 is written next with the control byte:
  - bit 7 = 0 for a 4-byte transfer, 1 otherwise;
  - bit 6 = 0 for a write, 1 for a read;
  - bits 5..0 = the address modifier with its bit order reversed (0x39 is written as 0x27).
- R4: For a write transfer, the data bytes are written to the data locations in ascending order, before the strobe write:
  - size code 0 (1 byte): `req_wdata[7:0]` goes to location 51 if address bit 0 is 1, and to location 50 if it is 0;
  - size code 1 (2 bytes): bits 15..8 go to 50 and bits 7..0 go to 51;
  - size codes 2 and 3 (4 bytes): bits 31..24, 23..16, 15..8 and 7..0 go to 48, 49, 50 and 51.
- R5: The strobe write goes to location 47. It has bit 2 = 1 (address strobe), and bits 7..3 are 0.
  - For a 1-byte transfer, bit 0 = address bit 0 and bit 1 = its inverse.
  - For a 2-byte or 4-byte transfer, bits 0 and 1 are both 1.
- R6: After the strobe write, location 47 is read repeatedly until a read returns a non-zero value. In that value, bit 0 means acknowledge.
- R7: On an acknowledged read transfer, the data locations in use are read in ascending order, using the same lane mapping as R4. The result in `rsp_rdata` is right-aligned, with the upper bytes 0.
- R8: If bit 1 of the polled status is set, bus error wins over acknowledge. `rsp_berr` = 1, `rsp_rdata` = 0, no data location is read, and the clearing write is still issued.
- R9: If POLL_LIMIT status reads in a row all return 0, then `rsp_tmo` = 1 and `rsp_rdata` = 0, and the clearing write is still issued.
- R10: Every bus transfer ends by writing 0 to location 47. This is followed by a `done` pulse lasting exactly one clock. The response outputs change only together with `done`, and `rsp_rdata` is 0 after any write.
- R11: Shadow capture and use:
  - A write request whose upper 24 address bits are 0 and whose low byte is BASE_OFF, BASE_OFF+1 or BASE_OFF+2 is captured, not sent to the bus.
  - It stores `req_wdata[7:0]` as the byte for location 42, 43 or 44 respectively.
  - It issues no I/O cycle and completes with `done`, with all flags 0.
  - A later request whose upper 24 bits are 0 uses the shadow bytes as its upper address. Any other request uses its own upper address bits.
- R12: Form of each controller I/O cycle:
  - `ctl_addr` and `ctl_wr_n` are set one clock before `ctl_ds_n` falls;
  - `ctl_ds_n` stays low for STB_CYCLES clocks, and address and write stay stable while it is low;
  - `ctl_doe` is 1 exactly in write cycles;
  - read data is sampled in the last low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | 32 | Bus byte address |
| req_am | input | 6 | Address modifier |
| req_write | input | 1 | 1 = write transfer |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_berr | output | 1 | Bus error reported by the status byte |
| rsp_tmo | output | 1 | Status poll limit reached |
| ctl_addr | output | 6 | Controller local location |
| ctl_dout | output | 8 | Controller data, outgoing |
| ctl_doe | output | 1 | Drive enable for `ctl_dout` |
| ctl_din | input | 8 | Controller data, incoming |
| ctl_wr_n | output | 1 | Controller write, active low |
| ctl_ds_n | output | 1 | Controller data strobe, active low |

## Verification
The assertions assume that `ctl_din` is settled in the last strobe cycle of a read. They also assume that reset is applied before the first request. The bench's controller model sets its data lines combinationally from `ctl_addr` and from its own poll counter. That counter advances only at the start of a strobe, so the value the block samples never changes while a strobe is low. The bench raises `req_valid` only after reset, and it leaves the request fields steady until the request is accepted.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  localparam logic [5:0] LOC_ADR3 = 6'd42;
  localparam logic [5:0] LOC_ADR2 = 6'd43;
  localparam logic [5:0] LOC_ADR1 = 6'd44;
  localparam logic [5:0] LOC_ADR0 = 6'd45;
  localparam logic [5:0] LOC_ACTL = 6'd46;
  localparam logic [5:0] LOC_STAT = 6'd47;
  localparam logic [5:0] LOC_DATA = 6'd48;

  typedef enum logic [3:0] {
    ST_A3, ST_A2, ST_A1, ST_A0, ST_CTRL, ST_WDAT, ST_GO, ST_POLL, ST_RDAT, ST_END
  } step_t;

  typedef enum logic [1:0] {M_IDLE, M_ISSUE, M_WAIT, M_FIN} mst_t;

  typedef enum logic [1:0] {IO_IDLE, IO_SETUP, IO_STB, IO_HOLD} io_ph_t;

  function automatic logic [5:0] rev6(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[5-i];
    return r;
  endfunction

  // bit i of the mask selects data location LOC_DATA+i
  function automatic logic [3:0] lane_mask(input logic one, input logic four,
                                           input logic odd);
    if (four)     return 4'b1111;
    else if (!one) return 4'b1100;
    else if (odd)  return 4'b1000;
    else           return 4'b0100;
  endfunction

endpackage

// File: rtl/vseq_iocyc.sv
module vseq_iocyc
  import vseq_pkg::*;
#(
  parameter int STB_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_wr,
  input  logic [5:0] op_addr,
  input  logic [7:0] op_data,
  output logic       io_done,
  output logic [7:0] io_rdata,
  output logic [5:0] ctl_addr,
  output logic [7:0] ctl_dout,
  output logic       ctl_doe,
  output logic       ctl_wr_n,
  output logic       ctl_ds_n,
  input  logic [7:0] ctl_din
);

  localparam int SCW = (STB_CYCLES > 1) ? $clog2(STB_CYCLES) : 1;
  localparam logic [SCW-1:0] STB_LAST = SCW'(STB_CYCLES - 1);

  io_ph_t         ph_q;
  logic [SCW-1:0] cnt_q;
  logic           wr_q;
  logic [5:0]     addr_q;
  logic [7:0]     data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= IO_IDLE;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      io_rdata <= '0;
    end else begin
      unique case (ph_q)
        IO_IDLE: if (start) begin
          wr_q   <= op_wr;
          addr_q <= op_addr;
          data_q <= op_data;
          ph_q   <= IO_SETUP;
        end
        IO_SETUP: begin
          cnt_q <= '0;
          ph_q  <= IO_STB;
        end
        IO_STB: begin
          if (cnt_q == STB_LAST) begin
            if (!wr_q) io_rdata <= ctl_din;
            ph_q <= IO_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= IO_IDLE;
      endcase
    end
  end

  logic active;
  assign active   = (ph_q != IO_IDLE);
  assign ctl_addr = addr_q;
  assign ctl_dout = data_q;
  assign ctl_doe  = active & wr_q;
  assign ctl_wr_n = ~(active & wr_q);
  assign ctl_ds_n = (ph_q != IO_STB);
  assign io_done  = (ph_q == IO_HOLD);

endmodule

// File: rtl/vseq_shadow.sv
module vseq_shadow #(
  parameter logic [7:0] BASE_OFF = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [7:0]  req_byte,
  input  logic        capture,
  output logic        base_hit,
  input  logic [23:0] cur_hi,
  output logic [23:0] eff_hi
);

  localparam int NSH = 3;

  logic [7:0] off;
  logic       hi_zero;
  logic [7:0] sh_q [NSH];

  assign off      = req_addr[7:0] - BASE_OFF;
  assign hi_zero  = (req_addr[31:8] == '0);
  assign base_hit = req_write & hi_zero & (off < 8'(NSH));

  for (genvar k = 0; k < NSH; k++) begin : g_sh
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               sh_q[k] <= '0;
      else if (capture && off == 8'(k))         sh_q[k] <= req_byte;
    end
  end

  assign eff_hi = (cur_hi == '0) ? {sh_q[0], sh_q[1], sh_q[2]} : cur_hi;

endmodule

// File: rtl/vseq_lanes.sv
module vseq_lanes (
  input  logic [3:0]  mask,
  input  logic [1:0]  cur,
  input  logic        one,
  input  logic [31:0] wdata,
  output logic [1:0]  first,
  output logic [1:0]  nxt,
  output logic        has_nxt,
  output logic [7:0]  wbyte
);

  logic [7:0] lane_b [4];

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_b[i] = one ? wdata[7:0] : wdata[8*(3-i) +: 8];
  end

  assign wbyte = lane_b[cur];

  always_comb begin
    first   = 2'd0;
    nxt     = 2'd0;
    has_nxt = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      if (mask[i]) first = 2'(i);
      if (mask[i] && 2'(i) > cur) begin
        nxt     = 2'(i);
        has_nxt = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vme_seq_master.sv
module vme_seq_master
  import vseq_pkg::*;
#(
  parameter int         STB_CYCLES = 2,
  parameter int         POLL_LIMIT = 64,
  parameter logic [7:0] BASE_OFF   = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [5:0]  req_am,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        done,
  output logic [31:0] rsp_rdata,
  output logic        rsp_berr,
  output logic        rsp_tmo,
  output logic [5:0]  ctl_addr,
  output logic [7:0]  ctl_dout,
  output logic        ctl_doe,
  input  logic [7:0]  ctl_din,
  output logic        ctl_wr_n,
  output logic        ctl_ds_n
);

  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam logic [PCW-1:0] PLIM = PCW'(POLL_LIMIT);

  mst_t           mst_q;
  step_t          step_q;
  logic [31:0]    a_q;
  logic [5:0]     am_q;
  logic           wr_q, one_q, four_q;
  logic [31:0]    wd_q;
  logic [1:0]     lane_q;
  logic [PCW-1:0] pcnt_q;
  logic           berr_q, tmo_q;
  logic [31:0]    acc_q;

  logic           accept, base_hit;
  logic [23:0]    eff_hi;
  logic [3:0]     mask;
  logic [1:0]     first_l, nxt_l;
  logic           has_nxt;
  logic [7:0]     wbyte;
  logic           io_start, io_done;
  logic [7:0]     io_rdata;
  logic           op_wr;
  logic [5:0]     op_addr;
  logic [7:0]     op_data;

  assign req_ready = (mst_q == M_IDLE);
  assign accept    = req_valid & req_ready;
  assign done      = (mst_q == M_FIN);
  assign io_start  = (mst_q == M_ISSUE);
  assign mask      = lane_mask(one_q, four_q, a_q[0]);

  vseq_shadow #(.BASE_OFF(BASE_OFF)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .req_write(req_write), .req_addr(req_addr), .req_byte(req_wdata[7:0]),
    .capture(accept & base_hit), .base_hit(base_hit),
    .cur_hi(a_q[31:8]), .eff_hi(eff_hi)
  );

  vseq_lanes u_lanes (
    .mask(mask), .cur(lane_q), .one(one_q), .wdata(wd_q),
    .first(first_l), .nxt(nxt_l), .has_nxt(has_nxt), .wbyte(wbyte)
  );

  vseq_iocyc #(.STB_CYCLES(STB_CYCLES)) u_io (
    .clk(clk), .rst_n(rst_n), .start(io_start),
    .op_wr(op_wr), .op_addr(op_addr), .op_data(op_data),
    .io_done(io_done), .io_rdata(io_rdata),
    .ctl_addr(ctl_addr), .ctl_dout(ctl_dout), .ctl_doe(ctl_doe),
    .ctl_wr_n(ctl_wr_n), .ctl_ds_n(ctl_ds_n), .ctl_din(ctl_din)
  );

  // operation for the current step
  always_comb begin
    op_wr   = 1'b1;
    op_addr = LOC_STAT;
    op_data = '0;
    unique case (step_q)
      ST_A3:   begin op_addr = LOC_ADR3; op_data = eff_hi[23:16]; end
      ST_A2:   begin op_addr = LOC_ADR2; op_data = eff_hi[15:8];  end
      ST_A1:   begin op_addr = LOC_ADR1; op_data = eff_hi[7:0];   end
      ST_A0:   begin op_addr = LOC_ADR0; op_data = {a_q[7:1], 1'b0}; end
      ST_CTRL: begin op_addr = LOC_ACTL; op_data = {~four_q, ~wr_q, rev6(am_q)}; end
      ST_WDAT: begin op_addr = LOC_DATA + {4'd0, lane_q}; op_data = wbyte; end
      ST_GO:   begin
        op_addr = LOC_STAT;
        op_data = {5'd0, 1'b1, one_q ? ~a_q[0] : 1'b1, one_q ? a_q[0] : 1'b1};
      end
      ST_POLL: begin op_wr = 1'b0; op_addr = LOC_STAT; end
      ST_RDAT: begin op_wr = 1'b0; op_addr = LOC_DATA + {4'd0, lane_q}; end
      default: begin op_addr = LOC_STAT; op_data = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q     <= M_IDLE;
      step_q    <= ST_A3;
      a_q       <= '0;
      am_q      <= '0;
      wr_q      <= 1'b0;
      one_q     <= 1'b0;
      four_q    <= 1'b0;
      wd_q      <= '0;
      lane_q    <= '0;
      pcnt_q    <= '0;
      berr_q    <= 1'b0;
      tmo_q     <= 1'b0;
      acc_q     <= '0;
      rsp_rdata <= '0;
      rsp_berr  <= 1'b0;
      rsp_tmo   <= 1'b0;
    end else begin
      unique case (mst_q)
        M_IDLE: if (accept) begin
          a_q    <= req_addr;
          am_q   <= req_am;
          wr_q   <= req_write;
          one_q  <= (req_size == 2'd0);
          four_q <= req_size[1];
          wd_q   <= req_wdata;
          berr_q <= 1'b0;
          tmo_q  <= 1'b0;
          acc_q  <= '0;
          step_q <= ST_A3;
          if (base_hit) begin
            rsp_rdata <= '0;
            rsp_berr  <= 1'b0;
            rsp_tmo   <= 1'b0;
            mst_q     <= M_FIN;
          end else begin
            mst_q <= M_ISSUE;
          end
        end
        M_ISSUE: mst_q <= M_WAIT;
        M_WAIT: if (io_done) begin
          mst_q <= M_ISSUE;
          unique case (step_q)
            ST_A3:   step_q <= ST_A2;
            ST_A2:   step_q <= ST_A1;
            ST_A1:   step_q <= ST_A0;
            ST_A0:   step_q <= ST_CTRL;
            ST_CTRL: begin
              if (wr_q) begin
                step_q <= ST_WDAT;
                lane_q <= first_l;
              end else begin
                step_q <= ST_GO;
              end
            end
            ST_WDAT: begin
              if (has_nxt) lane_q <= nxt_l;
              else         step_q <= ST_GO;
            end
            ST_GO: begin
              step_q <= ST_POLL;
              pcnt_q <= PCW'(1);
            end
            ST_POLL: begin
              if (io_rdata[1]) begin
                berr_q <= 1'b1;
                step_q <= ST_END;
              end else if (io_rdata[0]) begin
                if (!wr_q) begin
                  step_q <= ST_RDAT;
                  lane_q <= first_l;
                end else begin
                  step_q <= ST_END;
                end
              end else if (pcnt_q == PLIM) begin
                tmo_q  <= 1'b1;
                step_q <= ST_END;
              end else begin
                pcnt_q <= pcnt_q + 1'b1;
              end
            end
            ST_RDAT: begin
              if (one_q) acc_q[7:0] <= io_rdata;
              else       acc_q[{~lane_q, 3'b000} +: 8] <= io_rdata;
              if (has_nxt) lane_q <= nxt_l;
              else         step_q <= ST_END;
            end
            default: begin
              mst_q     <= M_FIN;
              rsp_berr  <= berr_q;
              rsp_tmo   <= tmo_q;
              rsp_rdata <= (berr_q | tmo_q | wr_q) ? 32'd0 : acc_q;
            end
          endcase
        end
        default: mst_q <= M_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vseq_master_chk.sv
module vseq_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic [31:0] rsp_rdata,
  input logic        rsp_berr,
  input logic        rsp_tmo,
  input logic [5:0]  ctl_addr,
  input logic        ctl_doe,
  input logic        ctl_wr_n,
  input logic        ctl_ds_n
);

  // R1
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ctl_ds_n);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rsp_rdata) && $stable(rsp_berr) && $stable(rsp_tmo)));

  // R12
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_ds_n |=> (ctl_ds_n || ($stable(ctl_addr) && $stable(ctl_wr_n))));

  // R12
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_ds_n && !ctl_wr_n) |-> ctl_doe);

  // R12
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_ds_n && ctl_wr_n) |-> !ctl_doe);

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_berr && rsp_tmo));

  // R9
  err_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_berr || rsp_tmo) |-> (rsp_rdata == 32'd0));

endmodule

bind vme_seq_master vseq_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .rsp_rdata(rsp_rdata), .rsp_berr(rsp_berr), .rsp_tmo(rsp_tmo),
  .ctl_addr(ctl_addr), .ctl_doe(ctl_doe), .ctl_wr_n(ctl_wr_n), .ctl_ds_n(ctl_ds_n)
);

// File: tb/sim_vme_seq_master.sv
`timescale 1ns/1ps
module sim_vme_seq_master;

  localparam int         STB  = 2;
  localparam int         LIM  = 5;
  localparam logic [7:0] BOFF = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [5:0]  req_am = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rsp_rdata;
  logic        rsp_berr, rsp_tmo;
  logic [5:0]  ctl_addr;
  logic [7:0]  ctl_dout;
  logic        ctl_doe;
  logic [7:0]  ctl_din;
  logic        ctl_wr_n, ctl_ds_n;

  always #10 clk = ~clk;

  vme_seq_master #(.STB_CYCLES(STB), .POLL_LIMIT(LIM), .BASE_OFF(BOFF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_am(req_am), .req_write(req_write),
    .req_size(req_size), .req_wdata(req_wdata), .done(done),
    .rsp_rdata(rsp_rdata), .rsp_berr(rsp_berr), .rsp_tmo(rsp_tmo),
    .ctl_addr(ctl_addr), .ctl_dout(ctl_dout), .ctl_doe(ctl_doe),
    .ctl_din(ctl_din), .ctl_wr_n(ctl_wr_n), .ctl_ds_n(ctl_ds_n)
  );

  int total = 0;
  int bad = 0;

  // controller model
  int         poll_cnt = 0;
  int         stat_after = 1;
  logic [7:0] stat_code = 8'd0;
  logic [7:0] rd_b [4];
  int         io_count = 0;

  always_comb begin
    if (ctl_addr == 6'd47)
      ctl_din = (stat_code != 0 && poll_cnt >= stat_after) ? stat_code : 8'd0;
    else if (ctl_addr >= 6'd48 && ctl_addr <= 6'd51)
      ctl_din = rd_b[ctl_addr[1:0]];
    else
      ctl_din = 8'hEE;
  end

  // expected I/O cycles
  int         q_addr[$];
  bit         q_wr[$];
  logic [7:0] q_dat[$];
  string      q_tag[$];

  logic [7:0] sh_m [3];
  bit         busy = 1'b0;
  bit         done_seen = 1'b0;
  bit         prev_done = 1'b0;
  bit         prev_ds = 1'b1;
  logic [5:0] prev_addr = '0;
  logic [31:0] d_rdata;
  bit          d_berr, d_tmo;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      check(req_ready == !busy, "R1", "ready vs busy", 32'(req_ready), 32'(!busy));
      if (!ctl_ds_n && prev_ds) begin
        io_count++;
        check(ctl_doe == !ctl_wr_n, "R12", "drive enable", 32'(ctl_doe), 32'(!ctl_wr_n));
        if (q_addr.size() == 0) begin
          check(1'b0, "R10", "unexpected io cycle at", 32'(ctl_addr), 32'hFFFF);
        end else begin
          automatic int         ea = q_addr.pop_front();
          automatic bit         ew = q_wr.pop_front();
          automatic logic [7:0] ed = q_dat.pop_front();
          automatic string      et = q_tag.pop_front();
          check(32'(ctl_addr) == ea, et, "location", 32'(ctl_addr), ea);
          check(ctl_wr_n == !ew, et, "write line", 32'(ctl_wr_n), 32'(!ew));
          if (ew) check(ctl_dout == ed, et, "data byte", 32'(ctl_dout), 32'(ed));
        end
        if (ctl_addr == 6'd47) begin
          if (ctl_wr_n) poll_cnt++;
          else if (ctl_dout != 0) poll_cnt = 0;
        end
      end else if (!ctl_ds_n) begin
        check(ctl_addr == prev_addr, "R12", "address stable in strobe",
              32'(ctl_addr), 32'(prev_addr));
      end
      if (done) begin
        check(!prev_done, "R10", "done width", 32'(prev_done), 0);
        d_rdata   = rsp_rdata;
        d_berr    = rsp_berr;
        d_tmo     = rsp_tmo;
        done_seen = 1'b1;
        busy      = 1'b0;
      end
    end
    prev_done = done;
    prev_ds   = ctl_ds_n;
    prev_addr = ctl_addr;
  end

  function automatic logic [5:0] rev(input logic [5:0] v);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) r[i] = v[5-i];
    return r;
  endfunction

  task automatic push(input int a, input bit w, input logic [7:0] d, input string t);
    q_addr.push_back(a); q_wr.push_back(w); q_dat.push_back(d); q_tag.push_back(t);
  endtask

  logic [31:0] last_rd = '0;

  task automatic run(input logic [31:0] addr, input logic [5:0] am, input bit wr,
                     input logic [1:0] size, input logic [31:0] wdata,
                     input logic [7:0] code, input int after,
                     input logic [31:0] rdpat);
    bit          one, four, hit, got;
    logic [23:0] hi;
    int          locs[$];
    int          npoll, io0;
    logic [31:0] e_rd;
    bit          e_berr, e_tmo;
    check(rsp_rdata == last_rd, "R10", "held read data", rsp_rdata, last_rd);
    one  = (size == 2'd0);
    four = size[1];
    hit  = wr && addr[31:8] == 0 && addr[7:0] >= BOFF && addr[7:0] <= BOFF + 8'd2;
    e_rd = 0; e_berr = 0; e_tmo = 0;
    for (int i = 0; i < 4; i++) rd_b[i] = rdpat[8*(3-i) +: 8];
    stat_code = code; stat_after = after; poll_cnt = 0;
    if (hit) begin
      sh_m[addr[7:0] - BOFF] = wdata[7:0];
    end else begin
      hi = (addr[31:8] == 0) ? {sh_m[0], sh_m[1], sh_m[2]} : addr[31:8];
      push(42, 1, hi[23:16], "R2");
      push(43, 1, hi[15:8], "R2");
      push(44, 1, hi[7:0], "R2");
      push(45, 1, {addr[7:1], 1'b0}, "R2");
      push(46, 1, {!four, !wr, rev(am)}, "R3");
      if (four)      begin locs.push_back(48); locs.push_back(49); locs.push_back(50); locs.push_back(51); end
      else if (!one) begin locs.push_back(50); locs.push_back(51); end
      else           locs.push_back(addr[0] ? 51 : 50);
      if (wr)
        foreach (locs[k])
          push(locs[k], 1, one ? wdata[7:0] : wdata[8*(51-locs[k]) +: 8], "R4");
      push(47, 1, {5'd0, 1'b1, one ? !addr[0] : 1'b1, one ? addr[0] : 1'b1}, "R5");
      got   = (code != 0) && (after <= LIM);
      npoll = got ? after : LIM;
      for (int p = 0; p < npoll; p++) push(47, 0, 0, "R6");
      if (got && code[1]) e_berr = 1;
      else if (!got) e_tmo = 1;
      else if (!wr) begin
        foreach (locs[k]) begin
          push(locs[k], 0, 0, "R7");
          if (one) e_rd[7:0] = rd_b[locs[k] - 48];
          else     e_rd[8*(51-locs[k]) +: 8] = rd_b[locs[k] - 48];
        end
      end
      push(47, 1, 0, "R10");
    end
    io0 = io_count;
    @(posedge clk); #1;
    req_addr = addr; req_am = am; req_write = wr; req_size = size; req_wdata = wdata;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    busy = 1'b1;
    done_seen = 1'b0;
    while (!done_seen) @(posedge clk);
    check(d_rdata == e_rd, e_berr ? "R8" : (e_tmo ? "R9" : "R7"), "read data", d_rdata, e_rd);
    check(d_berr == e_berr, "R8", "bus error flag", 32'(d_berr), 32'(e_berr));
    check(d_tmo == e_tmo, "R9", "timeout flag", 32'(d_tmo), 32'(e_tmo));
    check(q_addr.size() == 0, "R10", "io cycles left", q_addr.size(), 0);
    if (hit) check(io_count == io0, "R11", "io cycles in capture", io_count - io0, 0);
    q_addr.delete(); q_wr.delete(); q_dat.delete(); q_tag.delete();
    last_rd = e_rd;
    @(negedge clk);
    check(!done, "R10", "done after pulse", 32'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) sh_m[i] = 8'd0;
    for (int i = 0; i < 4; i++) rd_b[i] = 8'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    check(done == 1'b0, "R1", "done after reset", 32'(done), 0);
    check(rsp_rdata == 0 && !rsp_berr && !rsp_tmo, "R1", "response after reset",
          rsp_rdata, 0);
    // R11 shadow capture of the three base bytes
    run({24'd0, BOFF},        6'h00, 1, 2'd0, 32'h12, 8'd0, 1, 0);
    run({24'd0, BOFF + 8'd1}, 6'h00, 1, 2'd0, 32'h34, 8'd0, 1, 0);
    run({24'd0, BOFF + 8'd2}, 6'h00, 1, 2'd0, 32'h56, 8'd0, 1, 0);
    // R7 4-byte read using shadow base, ack on third poll, R3 modifier 0x39
    run(32'h0000_0A40, 6'h39, 0, 2'd2, 0, 8'h01, 3, 32'hA1B2C3D4);
    // R4 2-byte write with absolute upper address
    run(32'hABCD_EF13, 6'h3D, 1, 2'd1, 32'h0000_BEEF, 8'h01, 1, 0);
    // R4 R5 1-byte odd write
    run(32'h0000_0021, 6'h09, 1, 2'd0, 32'h0000_005A, 8'h01, 2, 0);
    // R7 R5 1-byte even read, immediate ack
    run(32'h0000_0044, 6'h29, 0, 2'd0, 0, 8'h01, 1, 32'h11223344);
    // R7 1-byte odd read
    run(32'h0100_0033, 6'h0D, 0, 2'd0, 0, 8'h01, 1, 32'h55667788);
    // R8 2-byte read with bus error
    run(32'h0000_0102, 6'h39, 0, 2'd1, 0, 8'h02, 2, 32'hCAFEF00D);
    // R8 4-byte write with both status bits set
    run(32'h2000_0000, 6'h0F, 1, 2'd3, 32'h01020304, 8'h03, 1, 0);
    // R9 timeout: status never set
    run(32'h0000_0080, 6'h39, 0, 2'd2, 0, 8'h00, 1, 32'h99999999);
    // R9 timeout: ack arrives one poll too late
    run(32'h0000_0090, 6'h39, 0, 2'd1, 0, 8'h01, LIM + 1, 32'h12345678);
    // R11 base offset with nonzero upper bits goes to the bus
    run({24'h000100, BOFF + 8'd1}, 6'h39, 1, 2'd0, 32'h77, 8'h01, 1, 0);
    // R11 offset just past the shadow range goes to the bus
    run({24'd0, BOFF + 8'd3}, 6'h39, 1, 2'd0, 32'h66, 8'h01, 1, 0);
    // R6 ack exactly at the poll limit
    run(32'h0000_00F0, 6'h39, 0, 2'd2, 0, 8'h01, LIM, 32'h0BADBEEF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule